// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block produces the dot-by-dot memory access pattern that a tile-based background renderer needs. It runs its own dot and line counters. From them it decides, on every dot, whether a fetch is under way, which kind it is (tile name, attribute, low pattern plane or high pattern plane) and whether the dot is the address half or the data half of that fetch. Every access uses two dots on a bus whose low address byte shares the eight data pins. On the first dot the block drives the full address and raises a latch strobe, so that an outside latch can hold the low byte. On the second dot it releases the shared pins, raises a read strobe and captures the returned byte.

A companion scroll block supplies the current video address word. The sequencer turns that word into name, attribute and pattern addresses. It takes the tile index it fetched earlier in the same group to build the two pattern addresses. On the last dot of each eight-dot group it hands the two pattern bytes and the selected two-bit palette field to the pixel shifters. Near the end of each rendering line it fetches the first two tiles of the next line, then does two name reads whose data is thrown away. On every second frame it drops one dot. The output toward the shifters moves in lock step with the raster and has no back-pressure: the consumer has to accept each group-end pulse in the dot where it appears.

Top module: `tile_fetch_seq`

## Requirements
- R1: While reset is held, the dot and line counters read 0, the frame-parity flag reads 0, and the latch strobe, read strobe, pin drive enable and tile pulse are all low.
- R2: Dots count 0 to 340 and then wrap. The line counter advances on each wrap, and after the last line (TOTAL_LINES-1, the pre-render line) it returns to line 0. The frame-parity flag toggles on every return to line 0.
- R3: If rendering is enabled and the parity flag is 1 at the last dot of the pre-render line, the next dot is dot 1 of line 0. In every other case the next dot is dot 0.
- R4: No fetch happens (latch and read strobes both low) on dot 0, on dots 257 to 320, on lines from VIS_LINES up to the pre-render line, or while rendering is disabled.
- R5: Each fetch takes two dots. On the address dot the latch strobe and the pin drive enable are 1 and the read strobe is 0. On the data dot the read strobe is 1, the drive enable and latch strobe are 0, and the high address bits keep their address-dot value.
- R6: Inside each eight-dot group (phase = (dot-1) mod 8), phases 0-1 fetch the tile name, 2-3 the attribute, 4-5 the low pattern plane and 6-7 the high pattern plane.
- R7: The name-fetch address is 0x2000 OR vaddr[11:0].
- R8: The attribute-fetch address is 0x23C0 OR (vaddr[11:10] at bits 11:10) OR (vaddr[9:7] at bits 5:3) OR (vaddr[4:2] at bits 2:0).
- R9: The low-plane address is pat_sel at bit 12, the fetched tile index at bits 11:4, 0 at bit 3 and vaddr[14:12] at bits 2:0. The high-plane address is the same value plus 8.
- R10: Dots 321 to 336 repeat the group pattern for two prefetched tiles. Dots 337 to 340 do two name fetches (address on 337 and 339) and raise no tile pulse.
- R11: On phase 7 of every group in dots 1-256 and 321-336, tile_valid is 1, tile_lo holds the low-plane byte, tile_hi holds the byte on the data pins, and tile_pal holds bits {2q+1,2q} of the attribute byte, where q = {vaddr[6],vaddr[1]} sampled on the attribute address dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| render_en | input | 1 | Background rendering enable |
| vaddr | input | 15 | Current video address word from the scroll block |
| pat_sel | input | 1 | Pattern table half select |
| ad_in | input | 8 | Shared pins, read value |
| ad_out | output | 8 | Shared pins, low address byte on address dots |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ab_hi | output | 6 | Address bits 13:8 |
| ale | output | 1 | Low-address latch strobe |
| rd | output | 1 | Read strobe, data dot |
| dot | output | 9 | Current dot |
| line | output | 9 | Current line |
| odd_frame | output | 1 | Frame parity flag |
| tile_valid | output | 1 | Group-end pulse to the shifters |
| tile_lo | output | 8 | Low pattern plane byte |
| tile_hi | output | 8 | High pattern plane byte |
| tile_pal | output | 2 | Palette field selected from the attribute byte |

## Verification
The assertions assume that the memory answers within the data dot, and that vaddr and pat_sel stay constant from a group's name address dot to its final dot. Without that, the pattern and palette outputs would mix values from two groups. The bench holds each video address word for a whole group, changing it only on the group's last dot after that dot has been checked. It changes render_en only well away from the pre-render line's final dot, except in the case that deliberately tests skipping with rendering disabled. The memory model answers each read from the address latched on the previous strobe, so the read data depends on the address in the same way real memory does.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int unsigned DOT_W  = 9;
  localparam int unsigned ADDR_W = 14;

  localparam logic [DOT_W-1:0] LAST_DOT  = 9'd340;
  localparam logic [DOT_W-1:0] TILE_END  = 9'd256;
  localparam logic [DOT_W-1:0] PREF_BEG  = 9'd321;
  localparam logic [DOT_W-1:0] PREF_END  = 9'd336;
  localparam logic [DOT_W-1:0] DUMMY_BEG = 9'd337;

  typedef enum logic [1:0] {
    FK_NAME = 2'd0,
    FK_ATTR = 2'd1,
    FK_PLO  = 2'd2,
    FK_PHI  = 2'd3
  } fkind_t;

  typedef struct packed {
    logic   busy;     // a fetch occupies this dot
    logic   addr_ph;  // 1: address dot, 0: data dot
    fkind_t kind;
    logic   last;     // final dot of a tile group
  } slot_t;
endpackage

// File: rtl/tfs_raster.sv
module tfs_raster #(
  parameter int unsigned TOTAL_LINES = 262,
  parameter int unsigned VIS_LINES   = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       render_en,
  output logic [8:0] dot,
  output logic [8:0] line,
  output logic       odd,
  output logic       fetch_line
);
  import tfs_pkg::*;

  localparam logic [8:0] PRE_LINE = 9'(TOTAL_LINES - 1);
  localparam logic [8:0] VIS_LIM  = 9'(VIS_LINES);

  logic at_end;
  logic skip_now;

  assign at_end   = (dot == LAST_DOT) && (line == PRE_LINE);
  assign skip_now = at_end && odd && render_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
      odd  <= 1'b0;
    end else if (dot == LAST_DOT) begin
      if (line == PRE_LINE) begin
        line <= '0;
        odd  <= ~odd;
        dot  <= skip_now ? 9'd1 : 9'd0;
      end else begin
        line <= line + 9'd1;
        dot  <= 9'd0;
      end
    end else begin
      dot <= dot + 9'd1;
    end
  end

  assign fetch_line = (line < VIS_LIM) || (line == PRE_LINE);

  // R2
  dot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot <= LAST_DOT);

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line <= PRE_LINE);

  // R3
  odd_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && odd && render_en) |=> (dot == 9'd1 && line == 9'd0));

  // R3
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !(odd && render_en)) |=> (dot == 9'd0 && line == 9'd0));
endmodule

// File: rtl/tfs_slot.sv
module tfs_slot (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        dot,
  input  logic              fetch_ok,
  output tfs_pkg::slot_t    slot
);
  import tfs_pkg::*;

  logic [8:0] dm1;
  logic [2:0] phase;
  logic       in_tiles, in_pref, in_dummy;

  assign dm1      = dot - 9'd1;
  assign phase    = dm1[2:0];
  assign in_tiles = (dot >= 9'd1) && (dot <= TILE_END);
  assign in_pref  = (dot >= PREF_BEG) && (dot <= PREF_END);
  assign in_dummy = (dot >= DUMMY_BEG) && (dot <= LAST_DOT);

  always_comb begin
    slot.busy    = fetch_ok && (in_tiles || in_pref || in_dummy);
    slot.addr_ph = ~phase[0];
    slot.kind    = in_dummy ? FK_NAME : fkind_t'(phase[2:1]);
    slot.last    = fetch_ok && (in_tiles || in_pref) && (phase == 3'd7);
  end

  // R4
  idle_dot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == 9'd0) |-> !slot.busy);

  // R4
  idle_hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot > TILE_END && dot < PREF_BEG) |-> !slot.busy);
endmodule

// File: rtl/tfs_addr.sv
module tfs_addr (
  input  logic              clk,
  input  logic              rst_n,
  input  tfs_pkg::slot_t    slot,
  input  logic [14:0]       vaddr,
  input  logic              pat_sel,
  input  logic [7:0]        tile_idx,
  output logic [13:0]       bus_addr
);
  import tfs_pkg::*;

  logic [ADDR_W-1:0] addr_c;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    unique case (slot.kind)
      FK_NAME: addr_c = {2'b10, vaddr[11:0]};
      FK_ATTR: addr_c = {2'b10, vaddr[11:10], 4'b1111, vaddr[9:7], vaddr[4:2]};
      FK_PLO:  addr_c = {1'b0, pat_sel, tile_idx, 1'b0, vaddr[14:12]};
      FK_PHI:  addr_c = {1'b0, pat_sel, tile_idx, 1'b1, vaddr[14:12]};
      default: addr_c = '0;
    endcase
  end

  // hold the address through the data dot, whatever vaddr does meanwhile
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        addr_q <= '0;
    else if (slot.busy && slot.addr_ph) addr_q <= addr_c;
  end

  always_comb begin
    if (!slot.busy)       bus_addr = '0;
    else if (slot.addr_ph) bus_addr = addr_c;
    else                  bus_addr = addr_q;
  end
endmodule

// File: rtl/tfs_tile.sv
module tfs_tile (
  input  logic              clk,
  input  logic              rst_n,
  input  tfs_pkg::slot_t    slot,
  input  logic [7:0]        ad_in,
  input  logic [1:0]        quad_in,
  output logic [7:0]        tile_idx,
  output logic              tile_valid,
  output logic [7:0]        tile_lo,
  output logic [7:0]        tile_hi,
  output logic [1:0]        tile_pal
);
  import tfs_pkg::*;

  logic [7:0] attr_q;
  logic [7:0] plo_q;
  logic [1:0] quad_q;
  logic [7:0] attr_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile_idx <= '0;
      attr_q   <= '0;
      plo_q    <= '0;
      quad_q   <= '0;
    end else if (slot.busy) begin
      if (slot.addr_ph) begin
        if (slot.kind == FK_ATTR) quad_q <= quad_in;
      end else begin
        unique case (slot.kind)
          FK_NAME: tile_idx <= ad_in;
          FK_ATTR: attr_q   <= ad_in;
          FK_PLO:  plo_q    <= ad_in;
          default: ;
        endcase
      end
    end
  end

  assign attr_sh    = attr_q >> {quad_q, 1'b0};
  assign tile_valid = slot.last;
  assign tile_lo    = plo_q;
  assign tile_hi    = ad_in;
  assign tile_pal   = attr_sh[1:0];

  // R11
  pulse_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid |-> (slot.kind == FK_PHI && !slot.addr_ph));
endmodule

// File: rtl/tile_fetch_seq.sv
module tile_fetch_seq #(
  parameter int unsigned TOTAL_LINES = 262,
  parameter int unsigned VIS_LINES   = 240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        render_en,
  input  logic [14:0] vaddr,
  input  logic        pat_sel,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [5:0]  ab_hi,
  output logic        ale,
  output logic        rd,
  output logic [8:0]  dot,
  output logic [8:0]  line,
  output logic        odd_frame,
  output logic        tile_valid,
  output logic [7:0]  tile_lo,
  output logic [7:0]  tile_hi,
  output logic [1:0]  tile_pal
);
  import tfs_pkg::*;

  logic           fetch_line;
  slot_t          slot;
  logic [7:0]     tile_idx;
  logic [13:0]    bus_addr;

  tfs_raster #(.TOTAL_LINES(TOTAL_LINES), .VIS_LINES(VIS_LINES)) u_raster (
    .clk(clk), .rst_n(rst_n), .render_en(render_en),
    .dot(dot), .line(line), .odd(odd_frame), .fetch_line(fetch_line)
  );

  tfs_slot u_slot (
    .clk(clk), .rst_n(rst_n), .dot(dot),
    .fetch_ok(render_en && fetch_line), .slot(slot)
  );

  tfs_addr u_addr (
    .clk(clk), .rst_n(rst_n), .slot(slot), .vaddr(vaddr),
    .pat_sel(pat_sel), .tile_idx(tile_idx), .bus_addr(bus_addr)
  );

  tfs_tile u_tile (
    .clk(clk), .rst_n(rst_n), .slot(slot), .ad_in(ad_in),
    .quad_in({vaddr[6], vaddr[1]}), .tile_idx(tile_idx),
    .tile_valid(tile_valid), .tile_lo(tile_lo), .tile_hi(tile_hi),
    .tile_pal(tile_pal)
  );

  assign ale    = slot.busy && slot.addr_ph;
  assign rd     = slot.busy && !slot.addr_ph;
  assign ad_oe  = ale;
  assign ab_hi  = bus_addr[13:8];
  assign ad_out = ale ? bus_addr[7:0] : 8'h00;

  // R5
  ale_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> rd);

  // R5
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> $stable(ab_hi));

  // R5
  pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (!ad_oe && !ale));

  // R11
  pulse_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid |-> rd);
endmodule

// File: tb/test_tile_fetch_seq.sv
module test_tile_fetch_seq;
  localparam int unsigned TL = 4;
  localparam int unsigned VL = 2;
  localparam int unsigned WD_CYCLES = 100000;

  typedef struct packed {
    logic [14:0] v;
    logic        ps;
    logic [13:0] nt;
    logic [13:0] at;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{15'h0000, 1'b0, 14'h2000, 14'h23C0},
    '{15'h7FFF, 1'b1, 14'h2FFF, 14'h2FFF},
    '{15'h1234, 1'b0, 14'h2234, 14'h23E5},
    '{15'h4C5A, 1'b1, 14'h2C5A, 14'h2FC6},
    '{15'h2A85, 1'b0, 14'h2A85, 14'h2BE9},
    '{15'h0C42, 1'b1, 14'h2C42, 14'h2FC0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        render_en = 1'b1;
  logic [14:0] vaddr = '0;
  logic        pat_sel = 1'b0;
  logic [7:0]  ad_in;
  logic [7:0]  ad_out;
  logic        ad_oe, ale, rd, odd_frame, tile_valid;
  logic [5:0]  ab_hi;
  logic [8:0]  dot, line;
  logic [7:0]  tile_lo, tile_hi;
  logic [1:0]  tile_pal;
  logic [13:0] lat;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tile_fetch_seq #(.TOTAL_LINES(TL), .VIS_LINES(VL)) i_tile_fetch_seq (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .vaddr(vaddr),
    .pat_sel(pat_sel), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .ab_hi(ab_hi), .ale(ale), .rd(rd), .dot(dot), .line(line),
    .odd_frame(odd_frame), .tile_valid(tile_valid), .tile_lo(tile_lo),
    .tile_hi(tile_hi), .tile_pal(tile_pal)
  );

  function automatic logic [7:0] mem(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], a[1:0]};
  endfunction

  // memory model: latch the low byte on the strobe, answer on the read dot
  always @(posedge clk) if (ale) lat <= {ab_hi, ad_out};
  assign ad_in = rd ? mem(lat) : 8'h00;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (line %0d dot %0d)",
               req, act, exp, line, dot);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_to(input int l, input int d);
    for (int k = 0; k < 5000; k++) begin
      if (line == 9'(l) && dot == 9'(d)) return;
      step();
    end
  endtask

  initial begin
    #(WD_CYCLES * 5.0);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [13:0] plo;
    logic [13:0] obs;
    logic [7:0]  at_b;
    vaddr   = VEC[0].v;
    pat_sel = VEC[0].ps;
    repeat (3) step();
    // R1 reset state
    chk(dot == 0 && line == 0, "R1 counters", {line, dot}, 0);
    chk(odd_frame == 0, "R1 parity", odd_frame, 0);
    chk(!ale && !rd && !ad_oe && !tile_valid, "R1 strobes",
        {ale, rd, ad_oe, tile_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    wait_to(0, 1);

    // table walk: one tile group per vector on line 0
    for (int i = 0; i < 6; i++) begin
      obs = {ab_hi, ad_out};
      chk(ale && ad_oe && !rd, "R5 address dot", {ale, ad_oe, rd}, 3'b110);
      chk(obs == VEC[i].nt, "R7 name address", obs, VEC[i].nt);
      step();
      chk(rd && !ale && !ad_oe, "R5 data dot", {ale, ad_oe, rd}, 3'b001);
      chk(ab_hi == VEC[i].nt[13:8], "R5 high bits held", ab_hi, VEC[i].nt[13:8]);
      step();
      obs = {ab_hi, ad_out};
      chk(ale && obs == VEC[i].at, "R8 attribute address", obs, VEC[i].at);
      step(); step();
      plo = {1'b0, VEC[i].ps, mem(VEC[i].nt), 1'b0, VEC[i].v[14:12]};
      obs = {ab_hi, ad_out};
      chk(ale && obs == plo, "R9 low plane address", obs, plo);
      chk(!tile_valid, "R6 no pulse mid group", tile_valid, 0);
      step(); step();
      obs = {ab_hi, ad_out};
      chk(ale && obs == (plo | 14'h0008), "R9 high plane address", obs, plo | 14'h0008);
      step();
      chk(tile_valid && rd, "R11 group pulse", {tile_valid, rd}, 2'b11);
      chk(tile_lo == mem(plo), "R11 low byte", tile_lo, mem(plo));
      chk(tile_hi == mem(plo | 14'h0008), "R11 high byte", tile_hi, mem(plo | 14'h0008));
      at_b = mem(VEC[i].at) >> (2 * {VEC[i].v[6], VEC[i].v[1]});
      chk(tile_pal == at_b[1:0], "R11 palette field", tile_pal, at_b[1:0]);
      if (i < 5) begin
        vaddr   = VEC[i + 1].v;
        pat_sel = VEC[i + 1].ps;
        step();
      end
    end

    // R4 horizontal gap
    wait_to(0, 257);
    chk(!ale && !rd, "R4 dot 257 idle", {ale, rd}, 0);
    wait_to(0, 300);
    chk(!ale && !rd, "R4 dot 300 idle", {ale, rd}, 0);
    vaddr = VEC[2].v;

    // R10 prefetch and trailing name reads
    wait_to(0, 321);
    chk(ale && {ab_hi, ad_out} == VEC[2].nt, "R10 prefetch name", {ab_hi, ad_out}, VEC[2].nt);
    wait_to(0, 323);
    chk(ale && {ab_hi, ad_out} == VEC[2].at, "R10 prefetch attribute", {ab_hi, ad_out}, VEC[2].at);
    wait_to(0, 329);
    chk(ale && {ab_hi, ad_out} == VEC[2].nt, "R10 second prefetch", {ab_hi, ad_out}, VEC[2].nt);
    wait_to(0, 336);
    chk(tile_valid, "R10 prefetch pulse", tile_valid, 1);
    step();
    chk(ale && {ab_hi, ad_out} == VEC[2].nt, "R10 dummy name 337", {ab_hi, ad_out}, VEC[2].nt);
    step();
    chk(rd && !tile_valid, "R10 dummy read 338", {rd, tile_valid}, 2'b10);
    step();
    chk(ale && {ab_hi, ad_out} == VEC[2].nt, "R10 dummy name 339", {ab_hi, ad_out}, VEC[2].nt);
    step();
    chk(rd && !tile_valid, "R10 dummy read 340", {rd, tile_valid}, 2'b10);

    // R4 rendering disabled, then idle line
    wait_to(1, 0);
    render_en = 1'b0;
    step();
    chk(!ale && !rd, "R4 render off", {ale, rd}, 0);
    wait_to(1, 300);
    render_en = 1'b1;
    wait_to(2, 5);
    chk(!ale && !rd, "R4 idle line", {ale, rd}, 0);
    wait_to(3, 1);
    chk(ale, "R4 pre-render line fetches", ale, 1);

    // R2 and R3 frame wrap and skipped dot
    wait_to(3, 340);
    chk(odd_frame == 0, "R2 even frame", odd_frame, 0);
    step();
    chk(dot == 0 && line == 0 && odd_frame, "R2 wrap to dot 0", {odd_frame, line, dot}, 19'h40000);
    wait_to(3, 340);
    step();
    chk(dot == 1 && line == 0, "R3 odd frame skip", {line, dot}, 1);
    chk(odd_frame == 0, "R2 parity toggles", odd_frame, 0);
    wait_to(3, 340);
    step();
    chk(dot == 0, "R2 even frame no skip", dot, 0);
    render_en = 1'b0;
    wait_to(3, 340);
    chk(odd_frame == 1, "R2 parity before test", odd_frame, 1);
    step();
    chk(dot == 0 && line == 0, "R3 no skip when disabled", {line, dot}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule